// File: doc/BRIEF.md
# Receive DMA Bus Request Arbiter

This block sits between a receive FIFO and the system-bus master of a receive DMA engine. Each cycle it looks at how many words are waiting in the FIFO and decides three things: whether to ask for the bus, whether that request is urgent, and how many beats the next burst may carry. When the FIFO gets close to full, the request is marked urgent so that the bus arbiter serves the receive path ahead of other masters. The mark stays on until the FIFO has drained well below that point, so the priority does not flicker around a single level.

A 16-bit control word sets the behaviour. It holds an urgency enable, two 3-bit watermark fields in eighths of the FIFO depth, three flags that say which burst sizes the bus accepts, and a 2-bit cap on burst size in 32-bit words. The burst offered is the largest accepted size that the FIFO already holds and that the cap allows. While a request waits for its grant, the offered burst size is frozen so the bus master sees a stable value. The FIFO and the data movement itself are outside this block.

Top module: `rx_dma_bus_arbiter`

## Requirements
- R1: `bus_req` is registered and, one cycle after any clock edge, equals 1 exactly when `fill_lvl` was nonzero at that edge.
- R2: When control bit 9 (urgency enable) is 0, `bus_prio` is 0 in the following cycle.
- R3: With urgency in effect, the upper watermark is hi×DEPTH/8 words, with hi in control bits 8:6. A fill at or above it sets `bus_prio` in the following cycle.
- R4: With urgency in effect, the lower watermark is lo×DEPTH/8 words, with lo in control bits 5:3. A fill at or below it clears `bus_prio` in the following cycle. A fill strictly between the watermarks leaves `bus_prio` unchanged.
- R5: When lo is greater than or equal to hi, urgency is treated as disabled and `bus_prio` is 0 in the following cycle.
- R6: Control bits 2, 1 and 0 allow bursts of 16, 8 and 4 beats. Each beat is BEAT_WORDS words. `burst_beats` becomes the largest allowed size whose word count is no more than `fill_lvl` and no more than the cap. If no size qualifies, it becomes 1.
- R7: Control bits 15:14 set the cap in words. Value 2 means 32 words and value 3 means 64 words. Values 0 and 1 mean no cap.
- R8: While `bus_req` is 1 and `bus_gnt` is 0, `burst_beats` keeps its value in the next cycle.
- R9: During and just after reset, `bus_req` is 0, `bus_prio` is 0 and `burst_beats` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_lvl | input | $clog2(DEPTH+1) | Words currently held in the receive FIFO |
| arb_ctrl | input | 16 | Urgency enable, watermarks, burst cap and accepted burst sizes |
| bus_gnt | input | 1 | Bus grant to the receive DMA |
| bus_req | output | 1 | Bus request |
| bus_prio | output | 1 | Urgent-priority flag on the request |
| burst_beats | output | 5 | Offered burst length in beats (1, 4, 8 or 16) |

## Verification
The hardest case to reach is the hold band of the hysteresis. To see that `bus_prio` holds, the fill has to enter the band between the watermarks from both sides: once coming down from above the upper mark, and once coming up from below the lower mark. The control word must also stay valid while this happens. The directed part of the stimulus makes a slow rising and falling fill ramp under the default watermarks for this. After that, a random walk of the fill runs with mostly-enabled random control words, and it moves in steps small enough to stay inside the band for several cycles. A second hard case is a frozen burst under a withheld grant while the fill moves. Directed cycles cover it by dropping `bus_gnt` while the fill changes.

// File: rtl/rxarb_pkg.sv
package rxarb_pkg;

   // Control word field positions (the decode below relies on them)
   localparam int CAP_HI    = 15;
   localparam int CAP_LO    = 14;
   localparam int URG_BIT   = 9;
   localparam int HI_MSB    = 8;
   localparam int HI_LSB    = 6;
   localparam int LO_MSB    = 5;
   localparam int LO_LSB    = 3;
   localparam int BOK_MSB   = 2;

   localparam int CTRL_W    = 16;
   localparam int BEATS_W   = 5;   // holds 1, 4, 8, 16

   // Urgency on, upper mark 6/8, lower mark 2/8
   localparam logic [CTRL_W-1:0] RXARB_CTRL_DEFAULT = 16'h0390;

   typedef struct packed {
      logic [1:0] cap_sel;
      logic       urg_on;
      logic [2:0] hi_n;
      logic [2:0] lo_n;
      logic [2:0] burst_ok;
   } arb_cfg_t;

   function automatic arb_cfg_t decode_cfg(input logic [CTRL_W-1:0] c);
      arb_cfg_t r;
      r.cap_sel  = c[CAP_HI:CAP_LO];
      r.urg_on   = c[URG_BIT];
      r.hi_n     = c[HI_MSB:HI_LSB];
      r.lo_n     = c[LO_MSB:LO_LSB];
      r.burst_ok = c[BOK_MSB:0];
      return r;
   endfunction

endpackage

// File: rtl/rxarb_wmark.sv
module rxarb_wmark #(
   parameter int DEPTH = 128,
   parameter int FW    = $clog2(DEPTH+1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [FW-1:0] fill,
   input  logic          urg_on,
   input  logic [2:0]    hi_n,
   input  logic [2:0]    lo_n,
   output logic          prio_o
);

   localparam int CW    = FW + 4;
   localparam int EIGHT = DEPTH / 8;

   logic [CW-1:0] fill_w, hi_lvl, lo_lvl;
   logic          marks_ok, active, prio_q, prio_d;

   assign fill_w   = CW'(fill);
   assign hi_lvl   = CW'(hi_n) * CW'(EIGHT);
   assign lo_lvl   = CW'(lo_n) * CW'(EIGHT);
   assign marks_ok = (lo_n < hi_n);
   assign active   = urg_on && marks_ok;

   always_comb begin
      prio_d = prio_q;
      if (!active)                 prio_d = 1'b0;
      else if (fill_w >= hi_lvl)   prio_d = 1'b1;
      else if (fill_w <= lo_lvl)   prio_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio_q <= 1'b0;
      else        prio_q <= prio_d;
   end

   assign prio_o = prio_q;

   // R2
   urg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !urg_on |=> !prio_q);

   // R5
   bad_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_n >= hi_n) |=> !prio_q);

   // R3
   hi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (urg_on && lo_n < hi_n && fill_w >= hi_lvl) |=> prio_q);

   // R4
   lo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (urg_on && lo_n < hi_n && fill_w <= lo_lvl) |=> !prio_q);

   // R4
   band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (urg_on && lo_n < hi_n && fill_w > lo_lvl && fill_w < hi_lvl) |=> $stable(prio_q));

endmodule

// File: rtl/rxarb_burst.sv
module rxarb_burst #(
   parameter int DEPTH      = 128,
   parameter int BEAT_WORDS = 4,
   parameter int FW         = $clog2(DEPTH+1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [FW-1:0]               fill,
   input  logic [1:0]                  cap_sel,
   input  logic [2:0]                  burst_ok,
   input  logic                        hold_i,
   output logic [rxarb_pkg::BEATS_W-1:0] beats_o
);
   import rxarb_pkg::*;

   localparam int NSIZE = 3;
   localparam int CW    = FW + 12;

   logic [CW-1:0]      fill_w, cap_words;
   logic               cap_on;
   logic [NSIZE-1:0]   fits;
   logic [BEATS_W-1:0] pick, beats_q;

   assign fill_w = CW'(fill);

   always_comb begin
      cap_on    = 1'b1;
      cap_words = CW'(0);
      case (cap_sel)
         2'd2:    cap_words = CW'(32);
         2'd3:    cap_words = CW'(64);
         default: cap_on    = 1'b0;
      endcase
   end

   // one comparator pair per burst size: 4, 8, 16 beats
   for (genvar i = 0; i < NSIZE; i++) begin : g_size
      localparam logic [CW-1:0] NEED = CW'((4 << i) * BEAT_WORDS);
      assign fits[i] = burst_ok[i] && (fill_w >= NEED) && (!cap_on || cap_words >= NEED);
   end

   always_comb begin
      pick = BEATS_W'(1);
      for (int i = 0; i < NSIZE; i++)
         if (fits[i]) pick = BEATS_W'(4 << i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       beats_q <= BEATS_W'(1);
      else if (!hold_i) beats_q <= pick;
   end

   assign beats_o = beats_q;

   // R6
   beats_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (beats_q == 5'd1 || beats_q == 5'd4 || beats_q == 5'd8 || beats_q == 5'd16));

   // R6
   beats_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_i |=> (beats_q == 5'd1 || CW'(beats_q) * CW'(BEAT_WORDS) <= $past(fill_w)));

   // R7
   cap_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_i && cap_sel[1]) |=> (beats_q == 5'd1 || CW'(beats_q) * CW'(BEAT_WORDS) <= $past(cap_words)));

   // R8
   grant_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> $stable(beats_q));

endmodule

// File: rtl/rx_dma_bus_arbiter.sv
module rx_dma_bus_arbiter #(
   parameter int DEPTH      = 128,
   parameter int BEAT_WORDS = 4,
   parameter int FW         = $clog2(DEPTH+1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [FW-1:0]                 fill_lvl,
   input  logic [rxarb_pkg::CTRL_W-1:0]  arb_ctrl,
   input  logic                          bus_gnt,
   output logic                          bus_req,
   output logic                          bus_prio,
   output logic [rxarb_pkg::BEATS_W-1:0] burst_beats
);
   import rxarb_pkg::*;

   if (DEPTH < 8 || DEPTH % 8 != 0) begin : g_bad_depth
      $error("DEPTH must be a nonzero multiple of 8");
   end
   if (BEAT_WORDS < 1) begin : g_bad_beat
      $error("BEAT_WORDS must be at least 1");
   end
   if (FW < $clog2(DEPTH+1)) begin : g_bad_fw
      $error("FW too narrow for DEPTH");
   end

   arb_cfg_t cfg;
   logic     req_q, hold;

   assign cfg  = decode_cfg(arb_ctrl);
   assign hold = req_q && !bus_gnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= (fill_lvl != '0);
   end

   rxarb_wmark #(.DEPTH(DEPTH), .FW(FW)) u_wmark (
      .clk    (clk),
      .rst_n  (rst_n),
      .fill   (fill_lvl),
      .urg_on (cfg.urg_on),
      .hi_n   (cfg.hi_n),
      .lo_n   (cfg.lo_n),
      .prio_o (bus_prio)
   );

   rxarb_burst #(.DEPTH(DEPTH), .BEAT_WORDS(BEAT_WORDS), .FW(FW)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .fill     (fill_lvl),
      .cap_sel  (cfg.cap_sel),
      .burst_ok (cfg.burst_ok),
      .hold_i   (hold),
      .beats_o  (burst_beats)
   );

   assign bus_req = req_q;

   // R1
   req_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (req_q == ($past(fill_lvl) != '0)));

   // R1
   prio_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_prio && cfg.urg_on && cfg.lo_n < cfg.hi_n) |-> req_q);

endmodule

// File: tb/rx_dma_bus_arbiter_test.sv
`timescale 1ns/1ps
module rx_dma_bus_arbiter_test;
   localparam int DEPTH = 128;
   localparam int BW    = 4;
   localparam int FW    = $clog2(DEPTH+1);
   localparam int EIGHT = DEPTH / 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [FW-1:0] fill_lvl = '0;
   logic [15:0]   arb_ctrl = 16'h0;
   logic          bus_gnt = 1'b1;
   logic          bus_req, bus_prio;
   logic [4:0]    burst_beats;

   int n_chk = 0;
   int n_bad = 0;
   logic       e_req = 1'b0, e_prio = 1'b0;
   logic [4:0] e_beats = 5'd1;

   always #4 clk = ~clk;

   rx_dma_bus_arbiter #(.DEPTH(DEPTH), .BEAT_WORDS(BW)) uut (
      .clk(clk), .rst_n(rst_n), .fill_lvl(fill_lvl), .arb_ctrl(arb_ctrl),
      .bus_gnt(bus_gnt), .bus_req(bus_req), .bus_prio(bus_prio),
      .burst_beats(burst_beats));

   function automatic logic [4:0] exp_beats(input int f, input logic [15:0] c);
      int cap, b;
      logic [4:0] r;
      cap = (c[15:14] == 2'd2) ? 32 : (c[15:14] == 2'd3) ? 64 : 1 << 20;
      r = 5'd1;
      for (int i = 0; i < 3; i++) begin
         b = 4 << i;
         if (c[i] && b*BW <= f && b*BW <= cap) r = 5'(b);
      end
      return r;
   endfunction

   function automatic logic exp_prio(input int f, input logic [15:0] c, input logic cur);
      int hi, lo;
      hi = int'(c[8:6]) * EIGHT;
      lo = int'(c[5:3]) * EIGHT;
      if (!c[9] || c[5:3] >= c[8:6]) return 1'b0;
      if (f >= hi) return 1'b1;
      if (f <= lo) return 1'b0;
      return cur;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d fill=%0d ctrl=%h", tag, act, exp, fill_lvl, arb_ctrl);
      end
   endtask

   task automatic step(input int f, input logic [15:0] c, input logic g);
      logic       n_req, n_prio;
      logic [4:0] n_beats;
      string      ptag, btag;
      fill_lvl = FW'(f);
      arb_ctrl = c;
      bus_gnt  = g;
      n_req   = (f != 0);
      n_prio  = exp_prio(f, c, e_prio);
      n_beats = (e_req && !g) ? e_beats : exp_beats(f, c);
      if (!c[9])                                  ptag = "R2";
      else if (c[5:3] >= c[8:6])                  ptag = "R5";
      else if (f >= int'(c[8:6]) * EIGHT)         ptag = "R3";
      else                                        ptag = "R4";
      if (e_req && !g)           btag = "R8";
      else if (c[15:14] >= 2'd2) btag = "R7";
      else                       btag = "R6";
      @(posedge clk);
      @(negedge clk);
      check("R1", bus_req, n_req);
      check(ptag, bus_prio, n_prio);
      check(btag, burst_beats, n_beats);
      e_req = n_req; e_prio = n_prio; e_beats = n_beats;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] dflt;
      int f;
      dflt = rxarb_pkg::RXARB_CTRL_DEFAULT | 16'h0007;
      void'($urandom(32'd4242));
      // R9: outputs during reset, with busy inputs
      fill_lvl = FW'(100); arb_ctrl = dflt; bus_gnt = 1'b1;
      repeat (3) @(negedge clk);
      check("R9", bus_req, 0);
      check("R9", bus_prio, 0);
      check("R9", burst_beats, 1);
      rst_n = 1'b1;
      fill_lvl = '0;
      @(negedge clk);
      check("R9", bus_req, 0);
      check("R9", burst_beats, 1);

      // R3/R4: slow ramp up then down under default marks (96 / 32)
      for (int v = 0; v <= DEPTH; v += 8) step(v, dflt, 1'b1);
      for (int v = DEPTH; v >= 0; v -= 8) step(v, dflt, 1'b1);
      // exact watermark boundaries
      step(95, dflt, 1'b1); step(96, dflt, 1'b1); step(33, dflt, 1'b1); step(32, dflt, 1'b1);

      // R2: enable cleared at high fill
      step(120, dflt & ~16'h0200, 1'b1);
      // R5: lo >= hi treated as disabled
      step(120, 16'h0200 | (16'd3 << 6) | (16'd3 << 3) | 16'h7, 1'b1);
      step(120, 16'h0200 | (16'd2 << 6) | (16'd5 << 3) | 16'h7, 1'b1);

      // R7: each cap setting at full fill
      for (int s = 0; s < 4; s++) step(DEPTH, dflt | 16'(s << 14), 1'b1);
      // R6: size flags and fallback
      step(20, (dflt & ~16'h7) | 16'h1, 1'b1);
      step(10, (dflt & ~16'h7) | 16'h1, 1'b1);
      step(40, (dflt & ~16'h7) | 16'h4, 1'b1);
      step(64, (dflt & ~16'h7) | 16'h4, 1'b1);
      step(0,  dflt, 1'b1);

      // R8: grant withheld while fill moves
      step(80, dflt, 1'b1);
      step(20, dflt, 1'b0);
      step(5,  dflt, 1'b0);
      step(70, dflt, 1'b1);

      // random walk
      f = 0;
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] c;
         c = 16'($urandom);
         if (($urandom % 4) != 0) c[9] = 1'b1;
         if (($urandom % 8) == 0) c = dflt;
         f = f + int'($urandom % 25) - 12;
         if (f < 0) f = 0;
         if (f > DEPTH) f = DEPTH;
         step(f, c, ($urandom % 3) != 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule